// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block tracks the low-power condition of a memory device from its clock-enable input. At every rising clock edge it compares the clock-enable level seen at the previous edge with the level seen now, and combines that pair with the command registered at the same edge. The result is a move into precharge power-down, active power-down or self refresh, or a move back to normal operation. Bank state decides which power-down flavour is used. Only self refresh is reachable through an auto-refresh command issued on the falling clock-enable edge.

Leaving a low-power state passes through a timed exit interval. During that interval only no-operation or deselect commands are legal. Power-down exit lasts a fixed number of cycles. Self-refresh exit lasts the longer of its own exit time and a mandatory minimum of 1000 cycles. The block drives enables for the command input receivers and for the clock receivers, and a flag that says whether ordinary commands may be issued. Any protocol breach sets a sticky violation flag, which only reset clears.

Top module: `cke_power_ctl`

## Requirements
- R1: While reset is low and after it is released, the state is normal (code 0) and the violation flag is 0. The previous clock-enable level is taken as low after reset, so a low clock-enable at the first edge after reset causes no entry.
- R2: In precharge power-down (code 1), active power-down (code 2) or self refresh (code 3), a clock-enable that is low at the edge keeps the state unchanged. Any command at that edge is ignored and does not set the violation flag.
- R3: In normal state, a clock-enable that goes high to low together with NOP (command 0) or deselect (command 1), with no burst in progress, enters code 1 if all banks are idle and code 2 if any bank is open.
- R4: In normal state, a clock-enable that goes high to low together with auto-refresh (command 2), with all banks idle and no burst, enters self refresh (code 3). If a bank is open, the state stays normal and the violation flag is set.
- R5: A clock-enable that goes low to high in code 1 or 2 moves to power-down exit (code 4). The state returns to normal at the PD_EXIT_CYCLES-th edge after the exit edge.
- R6: A clock-enable that goes low to high in code 3 moves to self-refresh exit (code 5). The state returns to normal at the N-th edge after the exit edge, where N is the larger of SR_EXIT_CYCLES and SR_MIN_CYCLES.
- R7: Any command other than 0 or 1 in these cases sets the violation flag: on the exit edge, or at any edge while in code 4 or 5. The exit timing is unaffected.
- R8: The input-buffer enable is 0 in codes 1, 2 and 3 and 1 otherwise. The clock-receiver enable is 0 only in code 3.
- R9: The commands-allowed flag is 1 only in normal state.
- R10: In normal state, a clock-enable falling while the burst indication is high sets the violation flag and the state stays normal. A falling clock-enable with a command other than 0, 1 or 2 does the same.
- R11: Once set, the violation flag stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all decisions on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable level at this edge |
| cmd | input | 3 | Registered command: 0 NOP, 1 deselect, 2 auto-refresh, 3 activate, 4 read, 5 write, 6 precharge, 7 mode set |
| allBanksIdle | input | 1 | 1 when every bank is precharged |
| burstActive | input | 1 | 1 while a read, write or snoop burst runs |
| pwrState | output | 3 | State code 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh, 4 power-down exit, 5 self-refresh exit |
| inBufEn | output | 1 | Enable for command and address input receivers |
| clkRxEn | output | 1 | Enable for clock receivers |
| cmdAllowed | output | 1 | Ordinary commands may be issued |
| violation | output | 1 | Sticky protocol breach flag |

## Verification
Directed sequences drive the falling clock-enable edge with NOP under idle banks and with deselect under open banks, which separates the two power-down flavours. Auto-refresh is driven under idle banks and under open banks, which separates self-refresh entry from a refused entry. Both exit intervals are timed to the exact edge, including the edge before the return to normal, and the 1000-cycle floor is checked. Breaches are injected one at a time (a burst on the falling edge, a read on the falling edge, an activate inside an exit interval) to show that each one sets the flag alone. A long random run then weights commands towards NOP inside low-power and exit states and mixes in bank and burst states, so that interleaved entries and exits are compared cycle by cycle against a reference model.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_DESEL = 3'd1,
    CMD_AREF  = 3'd2,
    CMD_ACT   = 3'd3,
    CMD_READ  = 3'd4,
    CMD_WRITE = 3'd5,
    CMD_PRE   = 3'd6,
    CMD_MSET  = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    PS_NORMAL = 3'd0,
    PS_PPD    = 3'd1,
    PS_APD    = 3'd2,
    PS_SREF   = 3'd3,
    PS_PDX    = 3'd4,
    PS_SRX    = 3'd5
  } pstate_e;

  typedef struct packed {
    logic loadPd;
    logic loadSr;
    logic tick;
  } cntStrobe_t;

endpackage

// File: rtl/cke_pwr_cnt.sv
module cke_pwr_cnt
  import cke_pwr_pkg::*;
#(
  parameter int PD_LOAD = 6,
  parameter int SR_LOAD = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntStrobe_t strobe,
  output logic       cntZero
);

  localparam int MAXLOAD = (PD_LOAD > SR_LOAD) ? PD_LOAD : SR_LOAD;
  localparam int CW      = $clog2(MAXLOAD + 1);
  localparam logic [CW-1:0] PD_INIT = CW'(PD_LOAD - 1);
  localparam logic [CW-1:0] SR_INIT = CW'(SR_LOAD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.loadPd) begin
      cnt <= PD_INIT;
    end else if (strobe.loadSr) begin
      cnt <= SR_INIT;
    end else if (strobe.tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  // R6: a running exit interval always counts down each cycle
  assert_count_down_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && !strobe.loadPd && !strobe.loadSr) |=> (cnt == $past(cnt) - 1'b1));

  // R5: a power-down exit event seeds the interval
  assert_pd_seed_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPd |=> (cnt == PD_INIT));

endmodule

// File: rtl/cke_pwr_ctrl.sv
module cke_pwr_ctrl
  import cke_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cke,
  input  logic [2:0] cmdRaw,
  input  logic       allBanksIdle,
  input  logic       burstActive,
  input  logic       cntZero,
  output cntStrobe_t strobe,
  output pstate_e    state,
  output logic       violation
);

  logic    ckePrev;
  logic    ckeFall;
  logic    ckeRise;
  logic    isQuiet;
  logic    violSet;
  pstate_e stateNext;
  cmd_e    cmd;

  assign cmd     = cmd_e'(cmdRaw);
  assign isQuiet = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
  assign ckeFall = ckePrev & ~cke;
  assign ckeRise = ~ckePrev & cke;

  always_comb begin
    stateNext = state;
    violSet   = 1'b0;
    strobe    = '0;
    case (state)
      PS_NORMAL: begin
        if (ckeFall) begin
          if (burstActive) begin
            violSet = 1'b1;
          end else if (isQuiet) begin
            stateNext = allBanksIdle ? PS_PPD : PS_APD;
          end else if (cmd == CMD_AREF && allBanksIdle) begin
            stateNext = PS_SREF;
          end else begin
            violSet = 1'b1;
          end
        end
      end
      PS_PPD, PS_APD: begin
        if (ckeRise) begin
          stateNext     = PS_PDX;
          strobe.loadPd = 1'b1;
          violSet       = !isQuiet;
        end
      end
      PS_SREF: begin
        if (ckeRise) begin
          stateNext     = PS_SRX;
          strobe.loadSr = 1'b1;
          violSet       = !isQuiet;
        end
      end
      PS_PDX, PS_SRX: begin
        violSet = !isQuiet;
        if (cntZero) begin
          stateNext = PS_NORMAL;
        end else begin
          strobe.tick = 1'b1;
        end
      end
      default: stateNext = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PS_NORMAL;
      ckePrev   <= 1'b0;
      violation <= 1'b0;
    end else begin
      state   <= stateNext;
      ckePrev <= cke;
      if (violSet) begin
        violation <= 1'b1;
      end
    end
  end

  // R2: low-power states hold while clock-enable stays low
  assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((state == PS_PPD || state == PS_APD || state == PS_SREF) && !cke)
    |=> (state == $past(state)));

  // R4: auto-refresh with an open bank never reaches self refresh
  assert_no_sref_open_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_NORMAL && ckeFall && !burstActive && cmd == CMD_AREF && !allBanksIdle)
    |=> (state == PS_NORMAL && violation));

  // R10: clock-enable dropping in a burst is flagged and refused
  assert_burst_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_NORMAL && ckeFall && burstActive)
    |=> (state == PS_NORMAL && violation));

  // R11: violation flag is sticky
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation);

endmodule

// File: rtl/cke_power_ctl.sv
module cke_power_ctl
  import cke_pwr_pkg::*;
#(
  parameter int PD_EXIT_CYCLES = 6,
  parameter int SR_EXIT_CYCLES = 24,
  parameter int SR_MIN_CYCLES  = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cke,
  input  logic [2:0] cmd,
  input  logic       allBanksIdle,
  input  logic       burstActive,
  output logic [2:0] pwrState,
  output logic       inBufEn,
  output logic       clkRxEn,
  output logic       cmdAllowed,
  output logic       violation
);

  localparam int SR_LOAD = (SR_EXIT_CYCLES > SR_MIN_CYCLES) ? SR_EXIT_CYCLES : SR_MIN_CYCLES;

  cntStrobe_t strobe;
  pstate_e    state;
  logic       cntZero;

  cke_pwr_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cke          (cke),
    .cmdRaw       (cmd),
    .allBanksIdle (allBanksIdle),
    .burstActive  (burstActive),
    .cntZero      (cntZero),
    .strobe       (strobe),
    .state        (state),
    .violation    (violation)
  );

  cke_pwr_cnt #(
    .PD_LOAD (PD_EXIT_CYCLES),
    .SR_LOAD (SR_LOAD)
  ) u_cnt (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cntZero (cntZero)
  );

  assign pwrState   = state;
  assign inBufEn    = !(state == PS_PPD || state == PS_APD || state == PS_SREF);
  assign clkRxEn    = (state != PS_SREF);
  assign cmdAllowed = (state == PS_NORMAL);

  // R9: commands are only allowed with all receivers on
  assert_allowed_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdAllowed |-> (inBufEn && clkRxEn));

endmodule

// File: tb/sim_cke_power_ctl.sv
`timescale 1ns/1ps
module sim_cke_power_ctl;

  localparam int PD_N = 6;
  localparam int SR_N = 1000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ckeV = 1'b0;
  logic [2:0] cmdV = 3'd0;
  logic       idleV = 1'b1;
  logic       burstV = 1'b0;
  logic [2:0] pwrState;
  logic       inBufEn, clkRxEn, cmdAllowed, violation;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cke_power_ctl u0 (
    .clk(clk), .rstN(rstN), .cke(ckeV), .cmd(cmdV),
    .allBanksIdle(idleV), .burstActive(burstV),
    .pwrState(pwrState), .inBufEn(inBufEn), .clkRxEn(clkRxEn),
    .cmdAllowed(cmdAllowed), .violation(violation)
  );

  // reference model built from the requirements
  int mState = 0;
  int mLeft = 0;
  bit mPrev = 0;
  bit mViol = 0;

  always @(posedge clk) begin
    bit quiet;
    if (!rstN) begin
      mState = 0; mLeft = 0; mPrev = 0; mViol = 0;
    end else begin
      quiet = (cmdV == 3'd0) || (cmdV == 3'd1);
      case (mState)
        0: if (mPrev && !ckeV) begin
             if (burstV) mViol = 1;
             else if (quiet) mState = idleV ? 1 : 2;
             else if (cmdV == 3'd2 && idleV) mState = 3;
             else mViol = 1;
           end
        1, 2: if (ckeV) begin mState = 4; mLeft = PD_N; if (!quiet) mViol = 1; end
        3: if (ckeV) begin mState = 5; mLeft = SR_N; if (!quiet) mViol = 1; end
        default: begin
          if (!quiet) mViol = 1;
          mLeft--;
          if (mLeft == 0) mState = 0;
        end
      endcase
      mPrev = ckeV;
    end
  end

  function automatic bit expInBuf(int s);
    return !(s == 1 || s == 2 || s == 3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit c, input int cm, input bit idle, input bit burst);
    ckeV = c; cmdV = cm[2:0]; idleV = idle; burstV = burst;
    @(posedge clk); #2;
  endtask

  task automatic doReset();
    rstN = 0; ckeV = 0; cmdV = 0; idleV = 1; burstV = 0;
    @(posedge clk); #2; @(posedge clk); #2;
    rstN = 1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errs++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state
    rstN = 0;
    @(posedge clk); #2;
    chk("R1 state in reset", pwrState, 0);
    chk("R1 violation in reset", violation, 0);
    @(posedge clk); #2;
    rstN = 1;
    cyc(0, 0, 1, 0);
    chk("R1 low cke after reset no entry", pwrState, 0);
    chk("R9 allowed in normal", cmdAllowed, 1);
    chk("R8 inbuf normal", inBufEn, 1);

    // R3 precharge power-down
    cyc(1, 0, 1, 0);
    cyc(0, 0, 1, 0);
    chk("R3 idle entry ppd", pwrState, 1);
    chk("R8 inbuf off ppd", inBufEn, 0);
    chk("R8 clkrx on ppd", clkRxEn, 1);
    chk("R9 disallowed ppd", cmdAllowed, 0);
    cyc(0, 4, 1, 0);
    chk("R2 stay ppd read ignored", pwrState, 1);
    chk("R2 no violation on ignored cmd", violation, 0);
    // R5 exit timing
    cyc(1, 0, 1, 0);
    chk("R5 pd exit state", pwrState, 4);
    chk("R8 inbuf on exit", inBufEn, 1);
    for (int i = 1; i < PD_N; i++) cyc(1, 1, 1, 0);
    chk("R5 still exiting one before end", pwrState, 4);
    cyc(1, 0, 1, 0);
    chk("R5 back to normal", pwrState, 0);

    // R3 active power-down
    cyc(0, 1, 0, 0);
    chk("R3 open bank entry apd", pwrState, 2);
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    for (int i = 0; i < PD_N; i++) cyc(1, 0, 0, 0);
    chk("R5 apd exit complete", pwrState, 0);

    // R4 self refresh entry and R6 exit
    cyc(0, 2, 1, 0);
    chk("R4 self refresh entry", pwrState, 3);
    chk("R8 clkrx off sref", clkRxEn, 0);
    cyc(0, 5, 1, 0);
    chk("R2 stay sref", pwrState, 3);
    cyc(1, 0, 1, 0);
    chk("R6 sr exit state", pwrState, 5);
    chk("R9 disallowed sr exit", cmdAllowed, 0);
    for (int i = 1; i < SR_N; i++) cyc(1, 0, 1, 0);
    chk("R6 still exiting at edge 999", pwrState, 5);
    cyc(1, 0, 1, 0);
    chk("R6 normal at edge 1000", pwrState, 0);
    chk("R7 clean exit no violation", violation, 0);

    // R4 refused with open bank
    cyc(0, 2, 0, 0);
    chk("R4 open bank stays normal", pwrState, 0);
    chk("R4 open bank violation", violation, 1);

    // R10 burst drop, R11 sticky
    doReset();
    cyc(1, 0, 1, 1);
    cyc(0, 0, 1, 1);
    chk("R10 burst drop stays normal", pwrState, 0);
    chk("R10 burst drop violation", violation, 1);
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0);
    chk("R11 violation sticky", violation, 1);

    // R10 illegal command on falling edge
    doReset();
    cyc(1, 0, 1, 0);
    cyc(0, 4, 1, 0);
    chk("R10 read on fall stays normal", pwrState, 0);
    chk("R10 read on fall violation", violation, 1);

    // R7 command inside exit interval
    doReset();
    cyc(1, 0, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(1, 0, 1, 0);
    chk("R7 clean before breach", violation, 0);
    cyc(1, 3, 1, 0);
    chk("R7 act in exit flagged", violation, 1);
    for (int i = 2; i < PD_N; i++) cyc(1, 0, 1, 0);
    chk("R7 exit timing kept", pwrState, 4);
    cyc(1, 0, 1, 0);
    chk("R7 exit ends on time", pwrState, 0);

    // random phase against the model
    doReset();
    begin
      bit c = 1;
      for (int n = 0; n < 40000; n++) begin
        int cm;
        if (n % 4000 == 3999) doReset();
        if ($urandom % 25 == 0) c = !c;
        if (mState != 0) cm = ($urandom % 100 < 97) ? int'($urandom % 2) : int'($urandom % 8);
        else cm = ($urandom % 10 == 0) ? 2 : int'($urandom % 8);
        cyc(c, cm, bit'($urandom % 2), ($urandom % 8 == 0));
        chk("R5 model state", pwrState, mState);
        chk("R11 model violation", violation, mViol);
        chk("R8 model inbuf", inBufEn, expInBuf(mState));
        chk("R8 model clkrx", clkRxEn, mState != 3);
        chk("R9 model allowed", cmdAllowed, mState == 0);
      end
    end
    summary();
  end

endmodule